// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands, `x` of M bits and `y` of N bits, and returns their full (M+N)-bit product `z`. It is purely combinational. Each partial-product bit is the AND of one bit of `x` with one bit of `y`. Every operand bit is broadcast across its row or column of the array. The partial products are reduced by rows of half-adder and full-adder cells, one row for each multiplier bit after the first.

Inside these rows no carry travels sideways. Each cell sends its carry down to the next row at the next higher weight. The rows therefore hand on a sum vector and a carry vector, not a resolved number. The first cell of each row gives one low product bit directly. After the last row, a ripple vector-merging adder adds the remaining sum and carry vectors to form the upper M product bits. The delay is about N-1 cell delays down the array plus the merge time.

The block is meant to sit between registers that the surrounding design owns. Both widths are parameters, with a default of 4x4. Both must be at least 2.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of unsigned operands, `z` equals `x` times `y`, computed with full precision over M+N bits.
- R2: Bit 0 of `z` equals the AND of bit 0 of `x` and bit 0 of `y`.
- R3: When either operand is zero, `z` is zero.
- R4: When `y` is 1, `z` equals `x` zero-extended. When `x` is 1, `z` equals `y` zero-extended.
- R5: With both operands at their maximum (all ones), `z` equals (2^M-1)(2^N-1). For 4x4 this is 225 (hex E1).
- R6: The vector-merging adder never produces a carry out of its M bits. The upper product bits come out correct even when the array is fully loaded.
- R7: When `y` is a power of two 2^k, `z` equals `x` shifted left by k.
- R8: The block holds no state. A change on `x` or `y` is visible on `z` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | M | Unsigned multiplicand |
| y | input | N | Unsigned multiplier |
| z | output | M+N | Unsigned product |

## Verification
The bench builds two copies of the block. The first uses the default 4x4 widths, which makes the whole 256-pair operand space small enough to sweep against a behavioural multiply. It also covers a table of hand-worked products and the zero, unit, power-of-two and all-ones corners. The second copy has an 8-bit multiplicand and a 6-bit multiplier. This unequal shape exercises full-adder rows at depth greater than two and a merging adder whose width differs from the row count. Because its space is too large to sweep, it is covered by random operands and its own all-ones corner.

// File: rtl/csa_mul_pkg.sv
// Package: shared constants and width helpers for the carry-save multiplier.
// Assumes: operand widths are positive integers.
package csa_mul_pkg;

    // Smallest operand width the array structure supports.
    localparam int CSA_MIN_WIDTH = 2;

    // Width of the full product of an m-bit and an n-bit operand.
    function automatic int prod_width(input int m, input int n);
        return m + n;
    endfunction

endpackage

// File: rtl/csa_half_cell.sv
// Half-adder cell: used where an array position has only two inputs.
// Assumes: nothing; pure combinational logic.
module csa_half_cell (
    input  logic a,
    input  logic b,
    output logic s,
    output logic co
);

    // Sum and carry of two bits.
    always_comb begin
        s  = a ^ b;
        co = a & b;
    end

endmodule

// File: rtl/csa_full_cell.sv
// Full-adder cell: used where an array position has three inputs.
// Assumes: nothing; pure combinational logic.
module csa_full_cell (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    // Sum and majority carry of three bits.
    always_comb begin
        s  = a ^ b ^ ci;
        co = (a & b) | (ci & (a ^ b));
    end

endmodule

// File: rtl/csa_merge_adder.sv
// Vector-merging adder: ripples the final sum and carry vectors of the
// array into resolved product bits.
// Assumes: W >= 1; the carry-in is zero.
module csa_merge_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);

    logic [W:0] rip;

    assign rip[0] = 1'b0;
    assign cout   = rip[W];

    // One full cell per bit, carry chained upward.
    for (genvar k = 0; k < W; k++) begin : g_bit
        csa_full_cell u_fa (
            .a  (a[k]),
            .b  (b[k]),
            .ci (rip[k]),
            .s  (sum[k]),
            .co (rip[k+1])
        );
    end

endmodule

// File: rtl/csa_array_mult.sv
// Carry-save array multiplier, unsigned M x N, fully combinational.
// Row 0 holds the partial products of y[0]. Each following row j adds the
// partial products of y[j] to the previous row's sum, shifted by one, and to
// the previous row's carries, which arrive at the same weight. Row 1 has no
// incoming carries, so it uses half cells. Bit 0 of row j is product bit j.
// The last row's vectors are resolved by a ripple merging adder.
// Assumes: M >= 2 and N >= 2.
module csa_array_mult
    import csa_mul_pkg::*;
#(
    parameter int M = 4,
    parameter int N = 4
) (
    input  logic [M-1:0]   x,
    input  logic [N-1:0]   y,
    output logic [M+N-1:0] z
);

    localparam int ZW = prod_width(M, N);

    logic [N-1:0][M-1:0] pp;      // partial products, row j = x & y[j]
    logic [N-1:0][M-1:0] row_s;   // sum vector leaving each row
    logic [N-1:1][M-1:0] row_c;   // carry vector leaving each row
    logic [M-1:0]        mrg_a;
    logic [M-1:0]        mrg_sum;
    logic                merge_cout;

    // Broadcast AND plane.
    for (genvar j = 0; j < N; j++) begin : g_pp_row
        for (genvar i = 0; i < M; i++) begin : g_pp_col
            assign pp[j][i] = x[i] & y[j];
        end
    end

    // Row 0 is the bare partial-product row.
    assign row_s[0] = pp[0];

    // Carry-save rows.
    for (genvar j = 1; j < N; j++) begin : g_row
        for (genvar i = 0; i < M; i++) begin : g_cell
            if (j == 1) begin : g_first
                if (i < M - 1) begin : g_ha
                    csa_half_cell u_ha (
                        .a  (pp[j][i]),
                        .b  (row_s[j-1][i+1]),
                        .s  (row_s[j][i]),
                        .co (row_c[j][i])
                    );
                end else begin : g_pass
                    assign row_s[j][i] = pp[j][i];
                    assign row_c[j][i] = 1'b0;
                end
            end else begin : g_later
                if (i < M - 1) begin : g_fa
                    csa_full_cell u_fa (
                        .a  (pp[j][i]),
                        .b  (row_s[j-1][i+1]),
                        .ci (row_c[j-1][i]),
                        .s  (row_s[j][i]),
                        .co (row_c[j][i])
                    );
                end else begin : g_ha
                    csa_half_cell u_ha (
                        .a  (pp[j][i]),
                        .b  (row_c[j-1][i]),
                        .s  (row_s[j][i]),
                        .co (row_c[j][i])
                    );
                end
            end
        end
    end

    // Low product bits come straight from the first cell of each row.
    for (genvar j = 0; j < N; j++) begin : g_low
        assign z[j] = row_s[j][0];
    end

    // Align the last sum vector with the last carry vector.
    assign mrg_a = {1'b0, row_s[N-1][M-1:1]};

    csa_merge_adder #(.W(M)) u_merge (
        .a    (mrg_a),
        .b    (row_c[N-1]),
        .sum  (mrg_sum),
        .cout (merge_cout)
    );

    // Upper product bits from the merging adder.
    assign z[ZW-1:N] = mrg_sum;

endmodule

// File: rtl/csa_array_mult_chk.sv
// Checker: property checks on the multiplier's ports and its merge carry.
// Assumes: bound to csa_array_mult with matching parameters.
module csa_array_mult_chk #(
    parameter int M = 4,
    parameter int N = 4
) (
    input logic [M-1:0]   x,
    input logic [N-1:0]   y,
    input logic [M+N-1:0] z,
    input logic           merge_cout
);

    localparam int ZW = M + N;

    // Combinational checks evaluated whenever the operands settle.
    always_comb begin
        a_r1_product: assert (z == ZW'(x) * ZW'(y))
            else $error("R1 product mismatch");
        a_r2_lsb: assert (z[0] == (x[0] & y[0]))
            else $error("R2 bit 0 mismatch");
        a_r3_zero: assert (!((x == '0) || (y == '0)) || (z == '0))
            else $error("R3 zero operand gave nonzero product");
        a_r4_unit: assert ((y != N'(1)) || (z == ZW'(x)))
            else $error("R4 multiply by one mismatch");
        a_r6_merge_no_carry: assert (merge_cout == 1'b0)
            else $error("R6 merging adder carried out");
    end

endmodule

bind csa_array_mult csa_array_mult_chk #(.M(M), .N(N)) u_chk (
    .x          (x),
    .y          (y),
    .z          (z),
    .merge_cout (merge_cout)
);

// File: tb/csa_array_mult_bench.sv
// Bench: 4x4 table, exhaustive sweep, corners; 8x6 random and corners.
module csa_array_mult_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_checks = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    logic [3:0]  xa, ya;
    logic [7:0]  za;
    logic [7:0]  xb;
    logic [5:0]  yb;
    logic [13:0] zb;

    csa_array_mult #(.M(4), .N(4)) u_csa_array_mult (.x(xa), .y(ya), .z(za));
    csa_array_mult #(.M(8), .N(6)) u_csa_array_mult_wide (.x(xb), .y(yb), .z(zb));

    // Table entries: {x, y, expected product}.
    localparam logic [15:0] VEC [8] = '{
        {4'd3,  4'd5,  8'd15},
        {4'd15, 4'd15, 8'd225},
        {4'd10, 4'd11, 8'd110},
        {4'd7,  4'd9,  8'd63},
        {4'd12, 4'd12, 8'd144},
        {4'd1,  4'd13, 8'd13},
        {4'd8,  4'd8,  8'd64},
        {4'd6,  4'd0,  8'd0}
    };

    task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_a(input logic [3:0] xv, input logic [3:0] yv);
        @(posedge clk);
        xa = xv;
        ya = yv;
        @(negedge clk);
    endtask

    task automatic apply_b(input logic [7:0] xv, input logic [5:0] yv);
        @(posedge clk);
        xb = xv;
        yb = yv;
        @(negedge clk);
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        xa = '0; ya = '0; xb = '0; yb = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R3: idle operands after start-up give zero.
        @(negedge clk);
        chk("R3 zero at start", 14'(za), 14'd0);

        // R1: table walk.
        for (int k = 0; k < 8; k++) begin
            apply_a(VEC[k][15:12], VEC[k][11:8]);
            chk("R1 table", 14'(za), 14'(VEC[k][7:0]));
        end

        // R1, R2: exhaustive 4x4 sweep against a behavioural multiply.
        for (int xi = 0; xi < 16; xi++) begin
            for (int yi = 0; yi < 16; yi++) begin
                apply_a(4'(xi), 4'(yi));
                chk("R1 sweep", 14'(za), 14'(xi * yi));
                chk("R2 lsb", 14'(za[0]), 14'(xi & yi & 1));
            end
        end

        // R3: zero on either side.
        apply_a(4'd0, 4'd13);
        chk("R3 x zero", 14'(za), 14'd0);
        apply_a(4'd11, 4'd0);
        chk("R3 y zero", 14'(za), 14'd0);

        // R4: unit operands.
        apply_a(4'd14, 4'd1);
        chk("R4 y one", 14'(za), 14'd14);
        apply_a(4'd1, 4'd9);
        chk("R4 x one", 14'(za), 14'd9);

        // R5, R6: full load drives the merging adder's top bit.
        apply_a(4'd15, 4'd15);
        chk("R5 max 4x4", 14'(za), 14'd225);
        chk("R6 upper bits 4x4", 14'(za[7:4]), 14'd14);

        // R7: power-of-two multiplier shifts.
        for (int k = 0; k < 4; k++) begin
            apply_a(4'd11, 4'(1 << k));
            chk("R7 shift", 14'(za), 14'(11 << k));
        end

        // R8: change inputs mid-cycle, no clock edge in between.
        @(negedge clk);
        xa = 4'd13;
        ya = 4'd6;
        #1;
        chk("R8 no clock", 14'(za), 14'd78);

        // R1: random operands on the 8x6 copy.
        for (int k = 0; k < 400; k++) begin
            logic [7:0] rx;
            logic [5:0] ry;
            rx = 8'($urandom);
            ry = 6'($urandom);
            apply_b(rx, ry);
            chk("R1 random 8x6", zb, 14'(rx) * 14'(ry));
        end

        // R5, R6: full load on the 8x6 copy.
        apply_b(8'hFF, 6'h3F);
        chk("R5 max 8x6", zb, 14'd16065);
        chk("R6 upper bits 8x6", 14'(zb[13:6]), 14'd251);

        // R7: power of two on the 8x6 copy.
        apply_b(8'd201, 6'd32);
        chk("R7 shift 8x6", zb, 14'd6432);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule